// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block turns bytes pushed by a host into asynchronous serial frames on a single output line. Characters are written into a 32-entry first-in first-out store. Whenever the transmitter is enabled and the store holds data, the next character is taken out, framed with a start bit, 5 to 8 data bits, an optional parity bit and one or two stop bits, and shifted out least-significant bit first. Frames follow one another with no idle gap until the store is empty.

Bit timing comes from a single-cycle enable pulse at sixteen times the bit rate. A busy output covers the whole job: characters waiting in the store and the frame still being shifted, up to the end of its last stop bit. The line-control inputs are sampled at the start of each frame. A break input holds the line low for as long as it is asserted. Dropping the store-enable input discards every waiting character. The frame already in the shift register still completes.

Top module: `txq_serializer`

## Requirements
- R1: The store holds 32 characters. `q_full` is high when 32 are held and `q_empty` is high when none are held. A write while full is dropped and leaves the stored contents unchanged.
- R2: While `tx_enable` is high, frames are sent back to back until the store is empty: a new frame starts on the same edge that ends the previous last stop bit. While `tx_enable` is low, no new frame starts.
- R3: After a clock edge at which a character is written into an empty store, `busy` is high.
- R4: `busy` goes low only after the store is empty and the last stop bit of the final frame has ended, or after a flush while no frame is active.
- R5: A frame is one low start bit followed by the data bits, least-significant first. The `word_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, and unused high bits are not sent.
- R6: The `par_mode` codes are 0 for none, 1 for even, 2 for odd, 3 for a constant 1 and 4 for a constant 0. Codes 5 to 7 mean none. The parity bit follows the last data bit, and even or odd parity covers only the data bits that are sent.
- R7: `two_stop` low sends one high stop bit and high sends two.
- R8: Every bit of a frame lasts exactly 16 `baud_tick` pulses. A bit ends at the clock edge that takes its 16th pulse.
- R9: While `force_break` is high, `txd` is low, whatever the transmitter is doing.
- R10: While `queue_en` is low, the store is emptied and writes are dropped. A frame already being shifted still completes.
- R11: `txd` is high when no frame is active and break is off, including while the transmitter is disabled.
- R12: Word length, parity mode and stop count are taken at the edge where a frame starts. Changes during the frame affect only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push `wr_data` into the store |
| wr_data | input | 8 | Character to send |
| tx_enable | input | 1 | Allow frames to start |
| queue_en | input | 1 | Store enable; low flushes the store |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| word_len | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| par_mode | input | 3 | 0 none, 1 even, 2 odd, 3 one, 4 zero |
| two_stop | input | 1 | 1 selects two stop bits |
| force_break | input | 1 | Hold `txd` low |
| txd | output | 1 | Serial output |
| busy | output | 1 | Store non-empty or frame in flight |
| q_full | output | 1 | Store holds 32 characters |
| q_empty | output | 1 | Store holds no characters |

## Verification
`q_full`, `q_empty` and `busy` are due one edge after the write, read or flush that moves them. `txd` takes the start bit on the edge that starts a frame and moves to the next bit on the edge that takes the 16th tick. `force_break` reaches `txd` in the same cycle, with no register in between. A behavioural model steps on each rising edge from the same inputs and predicts all four outputs. The bench compares the outputs on each falling edge, after every register has settled and before any input changes. Inputs change only one time unit after a rising edge, so design and model always sample the same values.

// File: rtl/txq_serializer.sv
module txq_serializer #(
  parameter int DEPTH = 32,
  parameter int OVS   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       tx_enable,
  input  logic       queue_en,
  input  logic       baud_tick,
  input  logic [1:0] word_len,
  input  logic [2:0] par_mode,
  input  logic       two_stop,
  input  logic       force_break,
  output logic       txd,
  output logic       busy,
  output logic       q_full,
  output logic       q_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int TW = $clog2(OVS);
  localparam int FW = 12;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          active;
  logic [TW-1:0] tc;
  logic [3:0]    left;
  logic [FW-1:0] sh;
  logic [FW-1:0] frame;
  logic [3:0]    flen;
  logic [7:0]    dmask;
  logic          par_on, par_bit;
  int            nbits;

  assign q_empty = (cnt == '0);
  assign q_full  = (cnt == (AW+1)'(DEPTH));

  wire bit_end = active && baud_tick && (tc == TW'(OVS-1));
  wire fin     = bit_end && (left == 4'd1);
  wire start   = tx_enable && queue_en && !q_empty && (!active || fin);
  wire push    = wr_en && queue_en && !q_full;

  always_comb begin
    nbits = 5 + int'(word_len);
    dmask = mem[rp];
    for (int i = 0; i < 8; i++)
      if (i >= nbits) dmask[i] = 1'b0;
    par_on = (par_mode >= 3'd1) && (par_mode <= 3'd4);
    case (par_mode)
      3'd1:    par_bit = ^dmask;
      3'd2:    par_bit = ~^dmask;
      3'd3:    par_bit = 1'b1;
      default: par_bit = 1'b0;
    endcase
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < nbits) frame[1+i] = dmask[i];
    if (par_on) frame[1+nbits] = par_bit;
    flen = 4'(1 + nbits + (par_on ? 1 : 0) + (two_stop ? 2 : 1));
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (!queue_en) begin
      rp  <= wp;
      cnt <= '0;
    end else begin
      if (push)  wp <= wp + 1'b1;
      if (start) rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(start);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      tc     <= '0;
      left   <= '0;
      sh     <= '1;
    end else if (start) begin
      active <= 1'b1;
      tc     <= '0;
      left   <= flen;
      sh     <= frame;
    end else if (bit_end) begin
      tc   <= '0;
      sh   <= {1'b1, sh[FW-1:1]};
      left <= left - 4'd1;
      if (left == 4'd1) active <= 1'b0;
    end else if (active && baud_tick) begin
      tc <= tc + 1'b1;
    end
  end

  assign txd  = force_break ? 1'b0 : (active ? sh[0] : 1'b1);
  assign busy = active || !q_empty;

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && queue_en && !start) |=> q_full);

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty && wr_en && queue_en) |=> busy);

  // R4
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (($past(active) && $past(left) == 4'd1) || !$past(queue_en)));

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !queue_en |=> q_empty);

  // R8
  hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !baud_tick && !start) |=> $stable(sh));

  // R5
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && !sh[0]));
endmodule

// File: tb/sim_txq_serializer.sv
`timescale 1ns/1ps
module sim_txq_serializer;
  localparam int DEPTH = 32;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, tx_enable = 0, queue_en = 1, baud_tick = 0;
  logic two_stop = 0, force_break = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] word_len = 2'd3;
  logic [2:0] par_mode = 3'd0;
  logic txd, busy, q_full, q_empty;

  int n_tests = 0, n_fail = 0;
  int tdiv = 2;
  int cyc = 0;

  always #4 clk = ~clk;

  txq_serializer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tx_enable(tx_enable), .queue_en(queue_en), .baud_tick(baud_tick),
    .word_len(word_len), .par_mode(par_mode), .two_stop(two_stop),
    .force_break(force_break), .txd(txd), .busy(busy),
    .q_full(q_full), .q_empty(q_empty)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 baud_tick <= (cyc % tdiv) == 0;
  end

  // behavioural reference
  byte unsigned mq[$];
  int  mbits[12];
  bit  m_act = 0;
  int  m_tc = 0, m_left = 0, m_pos = 0, m_sz = 0;
  bit  m_bend, m_st;

  function automatic void build(byte unsigned d);
    int n, k;
    bit p;
    n = 5 + int'(word_len);
    p = 0;
    mbits[0] = 0;
    for (int i = 0; i < n; i++) begin
      mbits[1+i] = d[i];
      p ^= d[i];
    end
    k = 1 + n;
    case (par_mode)
      3'd1: begin mbits[k] = p;  k++; end
      3'd2: begin mbits[k] = !p; k++; end
      3'd3: begin mbits[k] = 1;  k++; end
      3'd4: begin mbits[k] = 0;  k++; end
      default: ;
    endcase
    mbits[k] = 1; k++;
    if (two_stop) begin mbits[k] = 1; k++; end
    m_left = k;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_act = 0; m_tc = 0; m_left = 0; m_pos = 0;
    end else begin
      m_sz   = mq.size();
      m_bend = m_act && baud_tick && m_tc == 15;
      m_st   = tx_enable && queue_en && m_sz > 0 && (!m_act || (m_bend && m_left == 1));
      if (m_bend) begin
        m_tc = 0; m_pos++; m_left--;
        if (m_left == 0) m_act = 0;
      end else if (m_act && baud_tick) m_tc++;
      if (m_st) begin
        build(mq.pop_front());
        m_act = 1; m_tc = 0; m_pos = 0;
      end
      if (!queue_en) mq.delete();
      else if (wr_en && m_sz < DEPTH) mq.push_back(wr_data);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R5 R6 R7 R8 R9 R11 R12 txd", txd,
        force_break ? 0 : (m_act ? mbits[m_pos] : 1));
    chk("R2 R3 R4 busy", busy, m_act || mq.size() > 0);
    chk("R1 R10 q_full", q_full, mq.size() == DEPTH);
    chk("R1 R10 q_empty", q_empty, mq.size() == 0);
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(byte unsigned d);
    wr_en = 1; wr_data = d;
    tick(1);
    wr_en = 0;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 40000) begin @(negedge clk); g++; end
    chk("R4 drain", busy, 0);
    tick(1);
  endtask

  task automatic cfg(logic [1:0] wl, logic [2:0] pm, logic ts);
    word_len = wl; par_mode = pm; two_stop = ts;
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    #2;
    chk("R11 reset txd", txd, 1);
    chk("R4 reset busy", busy, 0);
    chk("R1 reset empty", q_empty, 1);
    chk("R1 reset full", q_full, 0);
    tick(1);

    // R3: busy visible right after the write edge
    tx_enable = 1; cfg(2'd3, 3'd0, 0);
    push(8'hA5);
    chk("R3 busy after write", busy, 1);
    wait_idle();

    // R5 R6 R7: several formats, back to back (R2)
    cfg(2'd0, 3'd1, 1);
    push(8'h13); push(8'h1C); push(8'hFF);
    wait_idle();
    cfg(2'd2, 3'd2, 0);
    push(8'h55); push(8'h7E);
    wait_idle();
    cfg(2'd1, 3'd3, 0);
    push(8'h2A);
    wait_idle();
    cfg(2'd1, 3'd4, 1);
    push(8'h3F);
    wait_idle();
    cfg(2'd3, 3'd6, 0);
    push(8'h81);
    wait_idle();

    // R12: settings changed mid-frame
    cfg(2'd3, 3'd1, 1);
    push(8'hC3); push(8'h0F);
    tick(60);
    cfg(2'd0, 3'd2, 0);
    wait_idle();

    // R2: disabled transmitter holds data; R1 fill and overflow
    tx_enable = 0;
    for (int i = 0; i < 34; i++) push(8'(i * 7 + 1));
    chk("R1 full after 32", q_full, 1);
    tick(100);
    chk("R2 no start while disabled", q_empty, 0);
    chk("R11 idle while disabled", txd, 1);
    tdiv = 1;
    cfg(2'd3, 3'd0, 0);
    tx_enable = 1;
    wait_idle();
    tdiv = 2;

    // R10: flush with no frame active
    tx_enable = 0;
    push(8'h11); push(8'h22); push(8'h33);
    queue_en = 0;
    tick(1);
    chk("R10 flush empties", q_empty, 1);
    chk("R10 busy after flush", busy, 0);
    push(8'h44);
    chk("R10 write ignored", q_empty, 1);
    queue_en = 1;
    tick(1);

    // R10: flush during a frame, frame completes
    tx_enable = 1;
    push(8'h96); push(8'h69);
    tick(40);
    queue_en = 0;
    tick(2);
    queue_en = 1;
    chk("R10 frame continues", busy, 1);
    wait_idle();

    // R9: break on idle and over a frame
    force_break = 1;
    tick(5);
    chk("R9 break idle", txd, 0);
    force_break = 0;
    push(8'hF0);
    tick(30);
    force_break = 1;
    tick(20);
    chk("R9 break in frame", txd, 0);
    force_break = 0;
    wait_idle();

    tick(5);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 190000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule